// File: doc/BRIEF.md
# Address and Data Breakpoint Comparator

This unit watches each access that a processor core reports on a monitor port: an instruction fetch, a data read or a data write, with its address and data word. Software programs a small bank of breakpoint descriptors. Each descriptor can be a single value to compare against, or the lower bound of an inclusive range whose upper bound sits in the next descriptor. A descriptor compares against either the access address or the access data word, and only for the access kinds it selects.

When an enabled descriptor matches and the unit-level enable is high, the unit raises a registered hit pulse together with the index of the matching descriptor. If several descriptors match at once, the lowest index is reported. The same hit also loads two nibble-wide emulator buses. One bus carries a 32-bit status word and the other carries the data word of the access that hit. Each word goes out as eight nibbles, most significant nibble first.

Top module: `bkpt_unit`

## Requirements
- R1: After reset, hit_o and emu_valid_o are low, and every descriptor is disabled with value 0.
- R2: A descriptor with enable set and range clear matches an access when the selected operand equals its value exactly. A target bit of 0 selects the address and 1 selects the data word.
- R3: Descriptor kind encoding: 0 matches fetches only, 1 data reads only, 2 data writes only, 3 any data read or write. Monitor kind encoding: 0 fetch, 1 read, 2 write, 3 no access (never matches).
- R4: A descriptor with enable clear never matches.
- R5: An even descriptor with the range bit set matches when lower <= operand <= upper, both ends inclusive. Its own value is the lower bound, the next descriptor's value is the upper bound, and its own enable, kind and target apply. While paired, the odd partner never matches on its own.
- R6: When several descriptors match the same access, hit_idx_o reports the lowest matching index.
- R7: hit_o goes high in the cycle after a matching access is sampled, for exactly one cycle per access. No hit is produced when mon_valid_i or unit_en_i is low.
- R8: On a hit, emu_stat_o emits the status word {4-bit index, 2-bit access kind, 2'b00, address[23:0]} as eight nibbles, MSB first. The first nibble appears together with hit_o, and emu_valid_o stays high for exactly those eight cycles.
- R9: In the same eight cycles, emu_data_o emits the data word of the hitting access, MSB first.
- R10: A configuration write updates one descriptor (value, enable, kind, target, range) at the selected index. The new value takes effect for accesses sampled after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| unit_en_i | input | 1 | Global breakpoint enable |
| cfg_we_i | input | 1 | Descriptor write strobe |
| cfg_idx_i | input | 3 | Descriptor index to write |
| cfg_en_i | input | 1 | Descriptor enable |
| cfg_kind_i | input | 2 | Descriptor access-kind selector |
| cfg_tgt_i | input | 1 | 0: compare address, 1: compare data |
| cfg_range_i | input | 1 | Range mode (even descriptors) |
| cfg_value_i | input | 32 | Descriptor compare value |
| mon_valid_i | input | 1 | Monitored access present |
| mon_kind_i | input | 2 | Monitored access kind |
| mon_addr_i | input | 32 | Monitored access address |
| mon_data_i | input | 32 | Monitored access data word |
| hit_o | output | 1 | Registered breakpoint pulse |
| hit_idx_o | output | 3 | Index of winning descriptor |
| emu_valid_o | output | 1 | Emulator buses carry a nibble |
| emu_stat_o | output | 4 | Status nibble stream |
| emu_data_o | output | 4 | Data nibble stream |

## Verification
The assertions take for granted that cfg_idx_i stays below the descriptor count during writes and that the monitor fields are stable, known values while mon_valid_i is high. The stimulus only writes legal indices and drives every monitor field at the falling edge with a defined value. While the status stream is being checked, the bench holds mon_valid_i low so that no fresh hit restarts the serialiser.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_READ  = 2'd1;
  localparam logic [1:0] KIND_WRITE = 2'd2;
  localparam logic [1:0] KIND_ANY   = 2'd3;

  typedef struct packed {
    logic       en;
    logic [1:0] kind;
    logic       tgt;
    logic       rng;
  } desc_ctrl_t;

  function automatic logic kind_ok(logic [1:0] dk, logic [1:0] mk);
    if (mk == KIND_ANY) return 1'b0;
    if (dk == KIND_ANY) return (mk == KIND_READ) || (mk == KIND_WRITE);
    return dk == mk;
  endfunction
endpackage

// File: rtl/bkpt_desc_regs.sv
module bkpt_desc_regs
  import bkpt_pkg::*;
#(
  parameter int N_DESC = 6,
  parameter int VAL_W  = 32,
  localparam int IDX_W = $clog2(N_DESC)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [IDX_W-1:0]              idx_i,
  input  desc_ctrl_t                    ctrl_i,
  input  logic [VAL_W-1:0]              value_i,
  output desc_ctrl_t [N_DESC-1:0]       ctrl_o,
  output logic [N_DESC-1:0][VAL_W-1:0]  val_o
);
  for (genvar i = 0; i < N_DESC; i++) begin : g_desc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctrl_o[i] <= '0;
        val_o[i]  <= '0;
      end else if (we_i && (idx_i == IDX_W'(i))) begin
        ctrl_o[i] <= ctrl_i;
        val_o[i]  <= value_i;
      end
    end
  end
endmodule

// File: rtl/bkpt_match.sv
module bkpt_match
  import bkpt_pkg::*;
#(
  parameter int N_DESC = 6,
  parameter int VAL_W  = 32
) (
  input  desc_ctrl_t [N_DESC-1:0]       ctrl_i,
  input  logic [N_DESC-1:0][VAL_W-1:0]  val_i,
  input  logic                          act_i,
  input  logic [1:0]                    kind_i,
  input  logic [VAL_W-1:0]              addr_i,
  input  logic [VAL_W-1:0]              data_i,
  output logic [N_DESC-1:0]             match_o
);
  for (genvar i = 0; i < N_DESC; i++) begin : g_cmp
    logic [VAL_W-1:0] op;
    logic             hit_val;
    logic             claimed;

    assign op = ctrl_i[i].tgt ? data_i : addr_i;

    // odd slot used as upper bound of a pair never matches alone
    if ((i % 2) == 1) begin : g_odd
      assign claimed = ctrl_i[i-1].rng;
    end else begin : g_even
      assign claimed = 1'b0;
    end

    if (((i % 2) == 0) && (i + 1 < N_DESC)) begin : g_pair
      always_comb begin
        if (ctrl_i[i].rng) hit_val = (op >= val_i[i]) && (op <= val_i[i+1]);
        else               hit_val = (op == val_i[i]);
      end
    end else begin : g_single
      assign hit_val = (op == val_i[i]);
    end

    assign match_o[i] = act_i && ctrl_i[i].en && !claimed &&
                        kind_ok(ctrl_i[i].kind, kind_i) && hit_val;
  end
endmodule

// File: rtl/bkpt_prio.sv
module bkpt_prio #(
  parameter int N_REQ  = 6,
  localparam int IDX_W = $clog2(N_REQ)
) (
  input  logic [N_REQ-1:0] req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_REQ - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/bkpt_emu_ser.sv
module bkpt_emu_ser #(
  parameter int WORD_W = 32,
  localparam int NIB   = WORD_W / 4,
  localparam int CNT_W = $clog2(NIB + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] stat_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              valid_o,
  output logic [3:0]        stat_o,
  output logic [3:0]        data_o
);
  logic [WORD_W-1:0] stat_q, data_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      data_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      stat_q <= stat_i;
      data_q <= data_i;
      cnt_q  <= CNT_W'(NIB);
    end else if (cnt_q != '0) begin
      stat_q <= {stat_q[WORD_W-5:0], 4'h0};
      data_q <= {data_q[WORD_W-5:0], 4'h0};
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign valid_o = (cnt_q != '0);
  assign stat_o  = valid_o ? stat_q[WORD_W-1 -: 4] : 4'h0;
  assign data_o  = valid_o ? data_q[WORD_W-1 -: 4] : 4'h0;
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int N_DESC = 6,
  parameter int AW     = 32,
  localparam int IDX_W = $clog2(N_DESC),
  localparam int STAT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             unit_en_i,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic             cfg_en_i,
  input  logic [1:0]       cfg_kind_i,
  input  logic             cfg_tgt_i,
  input  logic             cfg_range_i,
  input  logic [AW-1:0]    cfg_value_i,
  input  logic             mon_valid_i,
  input  logic [1:0]       mon_kind_i,
  input  logic [AW-1:0]    mon_addr_i,
  input  logic [AW-1:0]    mon_data_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] hit_idx_o,
  output logic             emu_valid_o,
  output logic [3:0]       emu_stat_o,
  output logic [3:0]       emu_data_o
);
  desc_ctrl_t [N_DESC-1:0]     ctrl;
  logic [N_DESC-1:0][AW-1:0]   val;
  logic [N_DESC-1:0]           match;
  logic                        any_hit;
  logic [IDX_W-1:0]            win_idx;
  desc_ctrl_t                  cfg_ctrl;
  logic [STAT_W-1:0]           stat_word;
  logic [STAT_W-1:0]           data_word;

  assign cfg_ctrl = '{en: cfg_en_i, kind: cfg_kind_i, tgt: cfg_tgt_i, rng: cfg_range_i};

  bkpt_desc_regs #(.N_DESC(N_DESC), .VAL_W(AW)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .idx_i  (cfg_idx_i),
    .ctrl_i (cfg_ctrl),
    .value_i(cfg_value_i),
    .ctrl_o (ctrl),
    .val_o  (val)
  );

  bkpt_match #(.N_DESC(N_DESC), .VAL_W(AW)) u_match (
    .ctrl_i (ctrl),
    .val_i  (val),
    .act_i  (mon_valid_i && unit_en_i),
    .kind_i (mon_kind_i),
    .addr_i (mon_addr_i),
    .data_i (mon_data_i),
    .match_o(match)
  );

  bkpt_prio #(.N_REQ(N_DESC)) u_prio (
    .req_i(match),
    .any_o(any_hit),
    .idx_o(win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o     <= 1'b0;
      hit_idx_o <= '0;
    end else begin
      hit_o     <= any_hit;
      if (any_hit) hit_idx_o <= win_idx;
    end
  end

  assign stat_word = {4'(win_idx), mon_kind_i, 2'b00, mon_addr_i[23:0]};
  assign data_word = STAT_W'(mon_data_i);

  bkpt_emu_ser #(.WORD_W(STAT_W)) u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (any_hit),
    .stat_i (stat_word),
    .data_i (data_word),
    .valid_o(emu_valid_o),
    .stat_o (emu_stat_o),
    .data_o (emu_data_o)
  );
endmodule

// File: rtl/bkpt_unit_chk.sv
module bkpt_unit_chk #(
  parameter int IDX_W  = 3,
  parameter int N_DESC = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             unit_en_i,
  input logic             mon_valid_i,
  input logic             hit_o,
  input logic [IDX_W-1:0] hit_idx_o,
  input logic             emu_valid_o,
  input logic [3:0]       emu_stat_o
);
  p_idx_legal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (int'(hit_idx_o) < N_DESC));

  p_no_hit_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mon_valid_i |=> !hit_o);

  p_no_hit_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unit_en_i |=> !hit_o);

  p_stream_with_hit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> emu_valid_o);

  p_first_nibble_idx_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (emu_stat_o == 4'(hit_idx_o)));

  p_stream_starts_on_hit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emu_valid_o && !hit_o) |-> $past(emu_valid_o));
endmodule

bind bkpt_unit bkpt_unit_chk #(.IDX_W(IDX_W), .N_DESC(N_DESC)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .unit_en_i  (unit_en_i),
  .mon_valid_i(mon_valid_i),
  .hit_o      (hit_o),
  .hit_idx_o  (hit_idx_o),
  .emu_valid_o(emu_valid_o),
  .emu_stat_o (emu_stat_o)
);

// File: tb/bkpt_unit_tb_top.sv
module bkpt_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        unit_en_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_idx_i = '0;
  logic        cfg_en_i = 1'b0;
  logic [1:0]  cfg_kind_i = '0;
  logic        cfg_tgt_i = 1'b0;
  logic        cfg_range_i = 1'b0;
  logic [31:0] cfg_value_i = '0;
  logic        mon_valid_i = 1'b0;
  logic [1:0]  mon_kind_i = 2'd3;
  logic [31:0] mon_addr_i = '0;
  logic [31:0] mon_data_i = '0;
  logic        hit_o;
  logic [2:0]  hit_idx_o;
  logic        emu_valid_o;
  logic [3:0]  emu_stat_o;
  logic [3:0]  emu_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_val [N];
  bit          m_en  [N];
  logic [1:0]  m_kind[N];
  bit          m_tgt [N];
  bit          m_rng [N];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bkpt_unit dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic prog(input int i, input bit en, input logic [1:0] k, input bit t,
                      input bit r, input logic [31:0] v);
    cfg_we_i = 1'b1; cfg_idx_i = 3'(i); cfg_en_i = en; cfg_kind_i = k;
    cfg_tgt_i = t; cfg_range_i = r; cfg_value_i = v;
    m_en[i] = en; m_kind[i] = k; m_tgt[i] = t; m_rng[i] = r; m_val[i] = v;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  function automatic bit kmatch(input logic [1:0] dk, input logic [1:0] mk);
    if (mk == 2'd3) return 1'b0;
    if (dk == 2'd3) return (mk == 2'd1) || (mk == 2'd2);
    return dk == mk;
  endfunction

  function automatic int model(input logic [1:0] mk, input logic [31:0] a, input logic [31:0] d);
    for (int i = 0; i < N; i++) begin
      logic [31:0] op;
      bit m;
      if ((i % 2 == 1) && m_rng[i-1]) continue;
      if (!m_en[i] || !kmatch(m_kind[i], mk)) continue;
      op = m_tgt[i] ? d : a;
      if ((i % 2 == 0) && (i + 1 < N) && m_rng[i]) m = (op >= m_val[i]) && (op <= m_val[i+1]);
      else m = (op == m_val[i]);
      if (m) return i;
    end
    return -1;
  endfunction

  task automatic access(input logic [1:0] mk, input logic [31:0] a, input logic [31:0] d,
                        input string req);
    int e;
    e = (unit_en_i) ? model(mk, a, d) : -1;
    mon_valid_i = 1'b1; mon_kind_i = mk; mon_addr_i = a; mon_data_i = d;
    @(negedge clk_i);
    mon_valid_i = 1'b0; mon_kind_i = 2'd3;
    chk(hit_o == (e >= 0), req, {31'd0, hit_o}, {31'd0, e >= 0});
    if (e >= 0) chk(int'(hit_idx_o) == e, req, {29'd0, hit_idx_o}, 32'(e));
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_val[i] = '0; m_en[i] = 0; m_kind[i] = '0; m_tgt[i] = 0; m_rng[i] = 0;
    end
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(hit_o == 1'b0, "R1 hit", {31'd0, hit_o}, 32'd0);
    chk(emu_valid_o == 1'b0, "R1 emu_valid", {31'd0, emu_valid_o}, 32'd0);
    rst_ni = 1'b1;
    unit_en_i = 1'b1;
    @(negedge clk_i);
    access(2'd1, 32'h0, 32'h0, "R1 cleared descriptors");

    // R2 R3 R4 R10 single-value sweep over index, kind, target
    for (int i = 0; i < N; i++) begin
      for (int k = 0; k < 4; k++) begin
        for (int t = 0; t < 2; t++) begin
          logic [31:0] v;
          v = 32'h1000 + 32'(i * 16) + 32'(k * 256) + 32'(t * 4096);
          prog(i, 1'b0, 2'(k), t[0], 1'b0, v);
          access(2'(k == 3 ? 1 : k), v, v, "R4 disabled");
          prog(i, 1'b1, 2'(k), t[0], 1'b0, v);
          for (int mk = 0; mk < 4; mk++) begin
            access(2'(mk), v, v ^ 32'h5, "R2 R3 R10 match addr");
            access(2'(mk), v ^ 32'h5, v, "R2 R3 R10 match data");
            access(2'(mk), v + 1, v - 1, "R2 miss");
          end
          prog(i, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0);
        end
      end
    end

    // R5 inclusive range per pair; partner enabled but must stay silent
    for (int p = 0; p < N / 2; p++) begin
      prog(2*p + 1, 1'b1, 2'd1, 1'b0, 1'b0, 32'h240);
      prog(2*p, 1'b1, 2'd3, 1'b0, 1'b1, 32'h200);
      for (int a = 32'h1fc; a <= 32'h244; a++) access(2'd1, 32'(a), 32'h0, "R5 range");
      access(2'd0, 32'h220, 32'h0, "R5 fetch outside kind");
      prog(2*p, 1'b1, 2'd3, 1'b1, 1'b1, 32'h200);
      access(2'd2, 32'h0, 32'h240, "R5 data upper edge");
      access(2'd2, 32'h0, 32'h1ff, "R5 data below");
      prog(2*p, 1'b0, 2'd3, 1'b0, 1'b0, 32'h0);
      access(2'd1, 32'h240, 32'h0, "R5 partner alone");
      prog(2*p + 1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0);
    end

    // R6 priority across every enable mask
    for (int m = 0; m < 64; m++) begin
      for (int i = 0; i < N; i++) prog(i, m[i], 2'd3, 1'b0, 1'b0, 32'hcafe0);
      access(2'd2, 32'hcafe0, 32'h1, "R6 lowest index");
    end

    // R7 gating by valid and unit enable
    prog(0, 1'b1, 2'd1, 1'b0, 1'b0, 32'h77);
    mon_kind_i = 2'd1; mon_addr_i = 32'h77; mon_valid_i = 1'b0;
    @(negedge clk_i);
    chk(hit_o == 1'b0, "R7 valid low", {31'd0, hit_o}, 32'd0);
    unit_en_i = 1'b0;
    access(2'd1, 32'h77, 32'h0, "R7 unit disabled");
    unit_en_i = 1'b1;

    // R8 R9 serial streams, R7 single-cycle pulse
    begin
      logic [31:0] sw, dw;
      prog(3, 1'b1, 2'd2, 1'b0, 1'b0, 32'h12a5c3e7);
      for (int i = 0; i < 3; i++) prog(i, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0);
      dw = 32'h9b8d4f61;
      sw = {4'd3, 2'd2, 2'b00, 24'ha5c3e7};
      access(2'd2, 32'h12a5c3e7, dw, "R8 hit");
      for (int n = 0; n < 8; n++) begin
        if (n > 0) begin
          @(negedge clk_i);
          chk(hit_o == 1'b0, "R7 one cycle", {31'd0, hit_o}, 32'd0);
        end
        chk(emu_valid_o == 1'b1, "R8 valid", {31'd0, emu_valid_o}, 32'd1);
        chk(emu_stat_o == sw[31-4*n -: 4], "R8 status nibble", {28'd0, emu_stat_o},
            {28'd0, sw[31-4*n -: 4]});
        chk(emu_data_o == dw[31-4*n -: 4], "R9 data nibble", {28'd0, emu_data_o},
            {28'd0, dw[31-4*n -: 4]});
      end
      @(negedge clk_i);
      chk(emu_valid_o == 1'b0, "R8 stream end", {31'd0, emu_valid_o}, 32'd0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule